// File: doc/BRIEF.md
# Operand Bypass and Hazard Unit

This unit sits at the issue point of an in-order integer pipeline. It picks the value for each of up to three source operands of the instruction waiting to issue. It can take that value from the register file read data, from a value it latched on an earlier cycle, or from one of several forwarding buses that later stages drive. Each forwarding bus carries a destination register number, a producer tag and data. The unit selects a bus by comparing register numbers directly. Buses that carry the result of a slow or performance-counter special-register read are never used.

A per-register in-flight record holds the tag of the youngest writer that has issued and not yet completed. An operand that has a pending writer stalls issue until one of two things happens: the value tagged by that youngest writer appears on a bus, or that writer completes. Any forwarded value for the wanted register is latched, even one from an older writer. So when the youngest writer completes with its write suppressed, the operand is the older writer's result, not a stale register file value. A completion that does write the register drops the latch, and the register file is read again.

Top module: `byp_hazard_unit`

## Requirements
- R1: After reset no register has a pending writer. An instruction whose sources are all free issues in the same cycle and takes each operand from rf_data_i, with select code 0.
- R2: A valid forwarding bus k whose register number equals a used source supplies that operand's data in the same cycle, with select code 2+k.
- R3: When several buses match the same source in one cycle, the lowest-numbered bus (the youngest producer) supplies the value.
- R4: A bus with its slow-read flag set is never selected and never releases a stall.
- R5: A source whose use flag is clear never causes a stall.
- R6: A used source whose register has a pending writer stalls issue. The stall ends in the same cycle that a bus presents the value whose tag equals the recorded youngest tag.
- R7: A matching forwarded value from an older writer is latched while the stall continues. On later cycles with no matching bus, the operand shows the latched value with select code 1.
- R8: When the youngest writer completes with its write suppressed, the pending record clears. The waiting instruction issues on the next cycle with the latched older value, select code 1.
- R9: A completion that writes the source register discards the latched value. From the next cycle the operand is taken from rf_data_i, select code 0.
- R10: An issuing instruction with dst_we_i set records dst_tag_i as the youngest writer of dst_reg_i. A completion that carries a different tag leaves the record pending.
- R11: stall_o is high only while in_valid_i is high, and issue_o equals in_valid_i and not stall_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An instruction is waiting to issue |
| src_use_i | input | NSRC | Per-source use flag |
| src_reg_i | input | NSRC x RW | Source register numbers |
| rf_data_i | input | NSRC x DW | Register file read data for each source |
| dst_we_i | input | 1 | Waiting instruction writes a register |
| dst_reg_i | input | RW | Its destination register |
| dst_tag_i | input | TW | Its tag |
| byp_valid_i | input | NB | Forwarding bus valid, bus 0 youngest |
| byp_slow_i | input | NB | Bus carries a slow or counter special-register read |
| byp_reg_i | input | NB x RW | Bus destination register |
| byp_tag_i | input | NB x TW | Bus producer tag |
| byp_data_i | input | NB x DW | Bus data |
| cmpl_valid_i | input | 1 | A writer completes this cycle |
| cmpl_reg_i | input | RW | Register of the completing writer |
| cmpl_tag_i | input | TW | Tag of the completing writer |
| cmpl_suppr_i | input | 1 | Completing writer's register write is suppressed |
| opd_o | output | NSRC x DW | Operand values |
| opd_sel_o | output | NSRC x SW | Operand source: 0 file, 1 latched, 2+k bus k |
| stall_o | output | 1 | Issue is held |
| issue_o | output | 1 | Instruction issues this cycle |

## Verification
The patterns are: a plain read with no pending writer, a single producer forwarded on one bus, two buses matching the same register with different tags, and a slow-read bus that must be ignored until the register file is written. These separate register-number matching, youngest-bus priority and the slow-read refusal. A write followed by a suppressed write to the same register, then a read, tells whether the latched older result is used instead of the stale file value. Two writers completing in turn to one register show that only the recorded tag clears the pending state. A reference model built on a queue of outstanding writers predicts stall and issue every cycle, and it predicts the architecturally correct operand at each issue.

// File: rtl/byp_pkg.sv
package byp_pkg;
  localparam int unsigned SEL_RF   = 0;
  localparam int unsigned SEL_HOLD = 1;
  localparam int unsigned SEL_BYP0 = 2;
endpackage

// File: rtl/byp_inflight.sv
module byp_inflight #(
  parameter int unsigned NREG = 32,
  parameter int unsigned TW   = 4,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_v_i,
  input  logic [RW-1:0]             alloc_reg_i,
  input  logic [TW-1:0]             alloc_tag_i,
  input  logic                      cmpl_v_i,
  input  logic [RW-1:0]             cmpl_reg_i,
  input  logic [TW-1:0]             cmpl_tag_i,
  output logic [NREG-1:0]           busy_o,
  output logic [NREG-1:0][TW-1:0]   tag_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_o[i] <= 1'b0;
        tag_o[i]  <= '0;
      end else if (alloc_v_i && alloc_reg_i == RW'(i)) begin
        busy_o[i] <= 1'b1;
        tag_o[i]  <= alloc_tag_i;
      end else if (cmpl_v_i && cmpl_reg_i == RW'(i) && cmpl_tag_i == tag_o[i]) begin
        busy_o[i] <= 1'b0;
      end
    end
  end

  a_r10_alloc_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_v_i |=> busy_o[$past(alloc_reg_i)]);

  a_r10_foreign_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_v_i && busy_o[cmpl_reg_i] && cmpl_tag_i != tag_o[cmpl_reg_i])
      |=> busy_o[$past(cmpl_reg_i)]);
endmodule

// File: rtl/byp_operand.sv
module byp_operand #(
  parameter int unsigned RW = 5,
  parameter int unsigned TW = 4,
  parameter int unsigned DW = 64,
  parameter int unsigned NB = 3,
  localparam int unsigned SW = $clog2(NB + 2)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   need_i,
  input  logic                   clr_i,
  input  logic [RW-1:0]          src_reg_i,
  input  logic                   busy_i,
  input  logic [TW-1:0]          busy_tag_i,
  input  logic [DW-1:0]          rf_data_i,
  input  logic [NB-1:0]          byp_valid_i,
  input  logic [NB-1:0]          byp_slow_i,
  input  logic [NB-1:0][RW-1:0]  byp_reg_i,
  input  logic [NB-1:0][TW-1:0]  byp_tag_i,
  input  logic [NB-1:0][DW-1:0]  byp_data_i,
  input  logic                   cmpl_v_i,
  input  logic [RW-1:0]          cmpl_reg_i,
  input  logic                   cmpl_suppr_i,
  output logic [DW-1:0]          data_o,
  output logic [SW-1:0]          sel_o,
  output logic                   ready_o
);
  import byp_pkg::*;

  logic [NB-1:0] match;
  logic          hit;
  logic [SW-1:0] hit_sel;
  logic [TW-1:0] hit_tag;
  logic [DW-1:0] hit_data;
  logic          hold_v_q;
  logic [DW-1:0] hold_q;

  for (genvar k = 0; k < NB; k++) begin : g_m
    assign match[k] = byp_valid_i[k] && !byp_slow_i[k] && byp_reg_i[k] == src_reg_i;
  end

  // descending scan: lowest index (youngest) overwrites
  always_comb begin
    hit      = 1'b0;
    hit_sel  = SW'(SEL_RF);
    hit_tag  = '0;
    hit_data = '0;
    for (int k = NB - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit      = 1'b1;
        hit_sel  = SW'(SEL_BYP0 + k);
        hit_tag  = byp_tag_i[k];
        hit_data = byp_data_i[k];
      end
    end
  end

  always_comb begin
    if (hit) begin
      data_o = hit_data;
      sel_o  = hit_sel;
    end else if (hold_v_q) begin
      data_o = hold_q;
      sel_o  = SW'(SEL_HOLD);
    end else begin
      data_o = rf_data_i;
      sel_o  = SW'(SEL_RF);
    end
  end

  assign ready_o = !need_i || !busy_i || (hit && hit_tag == busy_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else if (clr_i) begin
      hold_v_q <= 1'b0;
    end else if (hit) begin
      hold_v_q <= 1'b1;
      hold_q   <= hit_data;
    end else if (cmpl_v_i && !cmpl_suppr_i && cmpl_reg_i == src_reg_i) begin
      hold_v_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_chk
    a_r4_no_slow_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_o == SW'(SEL_BYP0 + k)) |->
        (byp_valid_i[k] && !byp_slow_i[k] && byp_reg_i[k] == src_reg_i));
    if (k > 0) begin : g_y
      a_r3_youngest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o == SW'(SEL_BYP0 + k)) |-> !(|match[k-1:0]));
    end
  end
endmodule

// File: rtl/byp_hazard_unit.sv
module byp_hazard_unit #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 64,
  parameter int unsigned TW   = 4,
  parameter int unsigned NSRC = 3,
  parameter int unsigned NB   = 3,
  localparam int unsigned RW  = $clog2(NREG),
  localparam int unsigned SW  = $clog2(NB + 2)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic [NSRC-1:0]          src_use_i,
  input  logic [NSRC-1:0][RW-1:0]  src_reg_i,
  input  logic [NSRC-1:0][DW-1:0]  rf_data_i,
  input  logic                     dst_we_i,
  input  logic [RW-1:0]            dst_reg_i,
  input  logic [TW-1:0]            dst_tag_i,
  input  logic [NB-1:0]            byp_valid_i,
  input  logic [NB-1:0]            byp_slow_i,
  input  logic [NB-1:0][RW-1:0]    byp_reg_i,
  input  logic [NB-1:0][TW-1:0]    byp_tag_i,
  input  logic [NB-1:0][DW-1:0]    byp_data_i,
  input  logic                     cmpl_valid_i,
  input  logic [RW-1:0]            cmpl_reg_i,
  input  logic [TW-1:0]            cmpl_tag_i,
  input  logic                     cmpl_suppr_i,
  output logic [NSRC-1:0][DW-1:0]  opd_o,
  output logic [NSRC-1:0][SW-1:0]  opd_sel_o,
  output logic                     stall_o,
  output logic                     issue_o
);
  logic [NREG-1:0]         busy;
  logic [NREG-1:0][TW-1:0] btag;
  logic [NSRC-1:0]         ready;

  assign stall_o = in_valid_i && !(&ready);
  assign issue_o = in_valid_i && !stall_o;

  byp_inflight #(.NREG(NREG), .TW(TW)) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_v_i   (issue_o && dst_we_i),
    .alloc_reg_i (dst_reg_i),
    .alloc_tag_i (dst_tag_i),
    .cmpl_v_i    (cmpl_valid_i),
    .cmpl_reg_i  (cmpl_reg_i),
    .cmpl_tag_i  (cmpl_tag_i),
    .busy_o      (busy),
    .tag_o       (btag)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    byp_operand #(.RW(RW), .TW(TW), .DW(DW), .NB(NB)) u_opd (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .need_i       (in_valid_i && src_use_i[s]),
      .clr_i        (issue_o || !(in_valid_i && src_use_i[s])),
      .src_reg_i    (src_reg_i[s]),
      .busy_i       (busy[src_reg_i[s]]),
      .busy_tag_i   (btag[src_reg_i[s]]),
      .rf_data_i    (rf_data_i[s]),
      .byp_valid_i  (byp_valid_i),
      .byp_slow_i   (byp_slow_i),
      .byp_reg_i    (byp_reg_i),
      .byp_tag_i    (byp_tag_i),
      .byp_data_i   (byp_data_i),
      .cmpl_v_i     (cmpl_valid_i),
      .cmpl_reg_i   (cmpl_reg_i),
      .cmpl_suppr_i (cmpl_suppr_i),
      .data_o       (opd_o[s]),
      .sel_o        (opd_sel_o[s]),
      .ready_o      (ready[s])
    );
  end

  a_r11_stall_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> in_valid_i);

  a_r5_unused_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && src_use_i == '0) |-> !stall_o);

  a_r1_free_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ((src_use_i & NSRC'(0)) == '0) && (busy == '0)) |-> issue_o);
endmodule

// File: tb/sim_byp_hazard_unit.sv
module sim_byp_hazard_unit;
  localparam int NREG = 32, DW = 64, TW = 4, NSRC = 3, NB = 3;
  localparam int RW = $clog2(NREG), SW = $clog2(NB + 2);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                    in_valid = 0, dst_we = 0, cmpl_valid = 0, cmpl_suppr = 0;
  logic [NSRC-1:0]         src_use = '0;
  logic [NSRC-1:0][RW-1:0] src_reg = '0;
  logic [NSRC-1:0][DW-1:0] rf_data;
  logic [RW-1:0]           dst_reg = '0, cmpl_reg = '0;
  logic [TW-1:0]           dst_tag = '0, cmpl_tag = '0;
  logic [NB-1:0]           byp_valid = '0, byp_slow = '0;
  logic [NB-1:0][RW-1:0]   byp_reg = '0;
  logic [NB-1:0][TW-1:0]   byp_tag = '0;
  logic [NB-1:0][DW-1:0]   byp_data = '0;
  logic [NSRC-1:0][DW-1:0] opd;
  logic [NSRC-1:0][SW-1:0] opd_sel;
  logic                    stall, issue;

  // bench-side register file and model state
  logic [DW-1:0] rf_m [NREG];
  logic [DW-1:0] arch_m [NREG];
  logic [DW-1:0] tag_val [16];
  int            q_reg[$];
  int            q_tag[$];
  logic [DW-1:0] dst_val = '0;
  logic          dst_sup = 0;
  logic          exp_issue;
  int checks = 0, errors = 0;

  for (genvar s = 0; s < NSRC; s++) begin : g_rf
    assign rf_data[s] = rf_m[src_reg[s]];
  end

  byp_hazard_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .src_use_i(src_use),
    .src_reg_i(src_reg), .rf_data_i(rf_data), .dst_we_i(dst_we), .dst_reg_i(dst_reg),
    .dst_tag_i(dst_tag), .byp_valid_i(byp_valid), .byp_slow_i(byp_slow),
    .byp_reg_i(byp_reg), .byp_tag_i(byp_tag), .byp_data_i(byp_data),
    .cmpl_valid_i(cmpl_valid), .cmpl_reg_i(cmpl_reg), .cmpl_tag_i(cmpl_tag),
    .cmpl_suppr_i(cmpl_suppr), .opd_o(opd), .opd_sel_o(opd_sel),
    .stall_o(stall), .issue_o(issue)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int newest(input int r);
    int n = -1;
    for (int i = 0; i < q_reg.size(); i++) if (q_reg[i] == r) n = i;
    return n;
  endfunction

  // sample mid-cycle, compare against model
  task automatic look();
    logic es;
    @(negedge clk);
    es = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (in_valid && src_use[s]) begin
        int n = newest(int'(src_reg[s]));
        if (n >= 0) begin
          int f = -1;
          for (int k = NB - 1; k >= 0; k--)
            if (byp_valid[k] && !byp_slow[k] && byp_reg[k] == src_reg[s]) f = k;
          if (!(f >= 0 && int'(byp_tag[f]) == q_tag[n])) es = 1'b1;
        end
      end
    end
    exp_issue = in_valid && !es;
    chk(stall == es, "R6 stall", DW'(stall), DW'(es));
    chk(issue == exp_issue, "R11 issue", DW'(issue), DW'(exp_issue));
    if (exp_issue)
      for (int s = 0; s < NSRC; s++)
        if (src_use[s])
          chk(opd[s] == arch_m[src_reg[s]], "R8 operand value", opd[s], arch_m[src_reg[s]]);
  endtask

  task automatic tick();
    @(posedge clk);
    if (cmpl_valid) begin
      int n = -1;
      for (int i = 0; i < q_tag.size(); i++) if (q_tag[i] == int'(cmpl_tag)) n = i;
      if (!cmpl_suppr) rf_m[cmpl_reg] = tag_val[cmpl_tag];
      if (n >= 0) begin
        // youngest writer done: it and older writers of that register leave
        for (int i = n; i >= 0; i--)
          if (q_reg[i] == int'(cmpl_reg)) begin q_reg.delete(i); q_tag.delete(i); end
      end
    end
    if (exp_issue && dst_we) begin
      q_reg.push_back(int'(dst_reg));
      q_tag.push_back(int'(dst_tag));
      tag_val[dst_tag] = dst_val;
      if (!dst_sup) arch_m[dst_reg] = dst_val;
    end
    #1;
  endtask

  task automatic produce(input int r, input int t, input logic [DW-1:0] v, input bit sup);
    in_valid = 1; src_use = '0; dst_we = 1; dst_reg = RW'(r); dst_tag = TW'(t);
    dst_val = v; dst_sup = sup;
    look(); tick();
    in_valid = 0; dst_we = 0; dst_sup = 0;
  endtask

  task automatic complete(input int r, input int t, input bit sup);
    cmpl_valid = 1; cmpl_reg = RW'(r); cmpl_tag = TW'(t); cmpl_suppr = sup;
    look(); tick();
    cmpl_valid = 0; cmpl_suppr = 0;
  endtask

  task automatic bus(input int k, input int r, input int t, input logic [DW-1:0] v,
                     input bit slow);
    byp_valid[k] = 1; byp_reg[k] = RW'(r); byp_tag[k] = TW'(t);
    byp_data[k] = v; byp_slow[k] = slow;
  endtask

  task automatic bus_off();
    byp_valid = '0; byp_slow = '0;
  endtask

  task automatic consumer(input int r0, input int r1, input int r2, input logic [2:0] use_m);
    in_valid = 1; dst_we = 0; src_use = use_m;
    src_reg[0] = RW'(r0); src_reg[1] = RW'(r1); src_reg[2] = RW'(r2);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      rf_m[i] = 64'h1000 + 64'(i);
      arch_m[i] = 64'h1000 + 64'(i);
    end
    for (int i = 0; i < 16; i++) tag_val[i] = '0;
    exp_issue = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state and free read
    look();
    chk(!stall && !issue, "R1 idle after reset", DW'({stall, issue}), 0);
    tick();
    consumer(3, 4, 0, 3'b011);
    look();
    chk(issue && opd_sel[0] == 0 && opd[0] == 64'h1003, "R1 free source from file",
        opd[0], 64'h1003);
    tick(); in_valid = 0;

    // R2 and R6 single producer forwarded on bus 1
    produce(5, 1, 64'hAAAA, 0);
    consumer(5, 0, 0, 3'b001);
    look(); chk(stall, "R6 pending writer stalls", DW'(stall), 1); tick();
    bus(1, 5, 1, 64'hAAAA, 0);
    look();
    chk(issue && opd_sel[0] == SW'(3) && opd[0] == 64'hAAAA, "R2 bus 1 selected",
        DW'(opd_sel[0]), 3);
    tick(); bus_off(); in_valid = 0;
    complete(5, 1, 0);

    // R3 two buses match one register
    produce(6, 2, 64'hB0B0, 0);
    produce(6, 3, 64'hC0C0, 0);
    consumer(6, 3, 0, 3'b011);
    bus(0, 6, 3, 64'hC0C0, 0);
    bus(2, 6, 2, 64'hB0B0, 0);
    look();
    chk(issue && opd_sel[0] == SW'(2) && opd[0] == 64'hC0C0, "R3 youngest bus wins",
        opd[0], 64'hC0C0);
    chk(opd_sel[1] == 0, "R1 other source from file", DW'(opd_sel[1]), 0);
    tick(); bus_off(); in_valid = 0;
    complete(6, 2, 0);
    complete(6, 3, 0);

    // R4 slow bus refused, R9 completion writes file
    produce(7, 4, 64'hE7E7, 0);
    consumer(0, 0, 7, 3'b100);
    bus(0, 7, 4, 64'hE7E7, 1);
    look();
    chk(stall && opd_sel[2] == 0, "R4 slow bus ignored", DW'(opd_sel[2]), 0);
    tick(); bus_off();
    complete(7, 4, 0);
    look();
    chk(issue && opd_sel[2] == 0 && opd[2] == 64'hE7E7, "R9 file after completion",
        opd[2], 64'hE7E7);
    tick(); in_valid = 0;

    // R5 unused pending source
    produce(8, 5, 64'hF8F8, 0);
    consumer(8, 3, 0, 3'b010);
    look(); chk(issue && !stall, "R5 unused source ignored", DW'(stall), 0);
    tick(); in_valid = 0;
    complete(8, 5, 0);

    // R7 R8 write, suppressed write, read
    produce(9, 6, 64'h6666, 0);
    produce(9, 7, 64'h7777, 1);
    consumer(0, 9, 0, 3'b010);
    look(); tick();
    bus(1, 9, 6, 64'h6666, 0);
    look();
    chk(stall && opd_sel[1] == SW'(3) && opd[1] == 64'h6666, "R7 older value on bus",
        opd[1], 64'h6666);
    tick(); bus_off();
    look();
    chk(stall && opd_sel[1] == SW'(1) && opd[1] == 64'h6666, "R7 older value latched",
        DW'(opd_sel[1]), 1);
    tick();
    complete(9, 7, 1);
    look();
    chk(issue && opd_sel[1] == SW'(1) && opd[1] == 64'h6666, "R8 latched after suppression",
        opd[1], 64'h6666);
    tick(); in_valid = 0;
    complete(9, 6, 0);

    // R10 foreign tag keeps pending, R9 final write
    produce(10, 8, 64'h8888, 0);
    produce(10, 9, 64'h9999, 0);
    consumer(10, 0, 0, 3'b001);
    complete(10, 8, 0);
    look(); chk(stall, "R10 older tag leaves pending", DW'(stall), 1); tick();
    complete(10, 9, 0);
    look();
    chk(issue && opd_sel[0] == 0 && opd[0] == 64'h9999, "R9 newest write from file",
        opd[0], 64'h9999);
    tick(); in_valid = 0;
    look(); chk(!stall, "R11 no stall when idle", DW'(stall), 0); tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule